// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block lets a clocked host reach an external asynchronous static RAM of one million 16-bit words. The host hands over one request at a time through a valid/ready handshake. Each request carries a 20-bit word address, a direction flag, 16 bits of write data and one enable bit per byte lane. The controller turns that request into a timed pin sequence on the memory side. That side has an active-low chip select, write enable and output enable, one active-low strobe per byte lane, and a data bus split into an output value, a drive enable and an input value.

Every access passes through three phases: setup, active and hold. The length of each phase is a whole number of clock cycles set by a parameter. Writes pulse write enable during the active phase only, and output enable stays inactive for the whole write. Reads pulse output enable during the active phase. The input bus is sampled on the last active cycle and returned to the host with a one-cycle response pulse. After reset, the controller waits a power-up interval before it accepts anything. The interval is given in microseconds and converted to cycles using the clock frequency parameter.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `req_ready` stays low for the first WAIT_CYC+1 clock edges (WAIT_CYC = CLK_MHZ*PWRUP_US, 18750 by default). It rises after edge WAIT_CYC+1, and no request is accepted before then.
- R2: When no access is in progress, chip select, write enable, output enable and all lane strobes are high, and the data bus is not driven.
- R3: A request with at least one enable bit set is accepted on a clock edge where `req_valid` and `req_ready` are both high. Chip select is then low for exactly SETUP_CYC+ACTIVE_CYC+HOLD_CYC cycles, starting the cycle after acceptance. For a write, write enable is low only during the ACTIVE_CYC cycles that follow the SETUP_CYC setup cycles.
- R4: During a write, output enable stays high for the whole access.
- R5: Host enable bit 0 drives strobe `sram_lane_n[0]` low for the access, and that strobe gates data bits 7:0. Enable bit 1 drives `sram_lane_n[1]`, which gates bits 15:8. A write changes only the memory bytes of enabled lanes.
- R6: During a read, write enable stays high and output enable is low exactly during the ACTIVE_CYC active cycles. `rsp_valid` is high for one cycle, the first hold cycle. It carries the bus value sampled on the last active cycle, with the bits of disabled lanes forced to zero, and `rsp_be` equal to the request's enables.
- R7: A request with both enable bits clear is accepted but leaves chip select high, and `req_ready` stays high. A read of this kind returns `rsp_valid` on the next cycle with `rsp_be` = 0 and data 0. A write of this kind leaves memory unchanged.
- R8: Address, lane strobes and write data come from the request captured at acceptance. They stay constant for the whole access, whatever the host does with its inputs meanwhile.
- R9: The bus is driven only during write accesses, from the first setup cycle through the last hold cycle. The bus is never driven while output enable is low, and output enable never falls in a cycle that directly follows a driven cycle.
- R10: `req_ready` is low from the cycle after acceptance until the access ends, and is high again in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| rsp_be | output | 2 | Lane enables used by the read |
| sram_addr | output | 20 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lane_n | output | 2 | Byte strobes, bit 0 lower, bit 1 upper, active low |
| sram_dq_out | output | 16 | Bus value when driven |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | 16 | Bus value from the memory |

## Verification
The bench holds a request pending through the whole power-up wait. A controller that counted the wait short would take that request early, and its pin activity would appear cycles before the model's. Single-lane writes are followed by reads with the opposite lane set and with both lanes set. A swapped or ignored strobe would then corrupt the neighbouring byte, or would leak the memory model's filler pattern into a lane that should read zero. All-disabled requests are mixed in, and the host inputs are scrambled while each access is under way. A controller that pulsed its strobes on an empty request, or that followed live host inputs instead of the captured copy, would show it directly on the address, data or strobe pins.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/sram_ctl_pwrup.sv
module sram_ctl_pwrup #(
  parameter int WAIT_CYC = 18750
) (
  input  logic clk,
  input  logic rst,
  output logic pwr_ok
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pwr_ok <= 1'b0;
    end else if (!pwr_ok) begin
      if (cnt_q == LAST) pwr_ok <= 1'b1;
      else               cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int ACTIVE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase,
  output phase_e phase_nxt,
  output logic   last
);
  localparam int MAXC = (SETUP_CYC > ACTIVE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((ACTIVE_CYC > HOLD_CYC) ? ACTIVE_CYC : HOLD_CYC);
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACTIVE = CNT_W'(ACTIVE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (start) phase_nxt = PH_SETUP;
      PH_SETUP:  if (last)  phase_nxt = PH_ACTIVE;
      PH_ACTIVE: if (last)  phase_nxt = PH_HOLD;
      PH_HOLD:   if (last)  phase_nxt = PH_IDLE;
      default:              phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      phase <= phase_nxt;
      if (phase_nxt != phase) begin
        unique case (phase_nxt)
          PH_SETUP:  cnt_q <= LD_SETUP;
          PH_ACTIVE: cnt_q <= LD_ACTIVE;
          PH_HOLD:   cnt_q <= LD_HOLD;
          default:   cnt_q <= '0;
        endcase
      end else if (!last) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              noop_rd,
  input  logic              pwr_ok,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  phase_e            phase,
  input  phase_e            phase_nxt,
  input  logic              last,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [LANES-1:0]  rsp_be,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_lane_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  logic             wr_q;
  logic [LANES-1:0] be_q;
  logic             wr_sel;
  logic [LANES-1:0] be_sel;
  logic             busy_nxt;
  logic             capture;

  assign wr_sel   = accept ? req_write : wr_q;
  assign be_sel   = accept ? req_be : be_q;
  assign busy_nxt = (phase_nxt != PH_IDLE);
  assign capture  = (phase == PH_ACTIVE) && last && !wr_q;

  // request capture, held for the whole access
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= 1'b0;
      be_q        <= '0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      wr_q        <= req_write;
      be_q        <= req_be;
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  // control pins, registered from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_cs_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      req_ready  <= 1'b0;
    end else begin
      sram_cs_n  <= !busy_nxt;
      sram_we_n  <= !((phase_nxt == PH_ACTIVE) && wr_sel);
      sram_oe_n  <= !((phase_nxt == PH_ACTIVE) && !wr_sel);
      sram_dq_oe <= busy_nxt && wr_sel;
      req_ready  <= pwr_ok && !busy_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_be    <= '0;
    end else begin
      rsp_valid <= capture || noop_rd;
      if (capture)      rsp_be <= be_q;
      else if (noop_rd) rsp_be <= '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        sram_lane_n[g]       <= 1'b1;
        rsp_rdata[g*8 +: 8]  <= '0;
      end else begin
        sram_lane_n[g] <= !(busy_nxt && be_sel[g]);
        if (capture)
          rsp_rdata[g*8 +: 8] <= be_q[g] ? sram_dq_in[g*8 +: 8] : 8'h00;
        else if (noop_rd)
          rsp_rdata[g*8 +: 8] <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CLK_MHZ    = 125,
  parameter int PWRUP_US   = 150,
  parameter int SETUP_CYC  = 2,
  parameter int ACTIVE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [DATA_W/8-1:0]   rsp_be,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_cs_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic [DATA_W/8-1:0]   sram_lane_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_in
);
  localparam int LANES    = DATA_W / 8;
  localparam int WAIT_CYC = CLK_MHZ * PWRUP_US;

  logic   pwr_ok;
  logic   take;
  logic   accept;
  logic   noop_rd;
  phase_e phase;
  phase_e phase_nxt;
  logic   last;

  assign take    = req_valid && req_ready && (phase == PH_IDLE);
  assign accept  = take && (|req_be);
  assign noop_rd = take && !(|req_be) && !req_write;

  sram_ctl_pwrup #(.WAIT_CYC(WAIT_CYC)) pwrup_i (
    .clk    (clk),
    .rst    (rst),
    .pwr_ok (pwr_ok)
  );

  sram_ctl_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .ACTIVE_CYC (ACTIVE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .last      (last)
  );

  sram_ctl_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) pins_i (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .noop_rd     (noop_rd),
    .pwr_ok      (pwr_ok),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .phase       (phase),
    .phase_nxt   (phase_nxt),
    .last        (last),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_be      (rsp_be),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_lane_n (sram_lane_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_in  (sram_dq_in)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 18750
) (
  input logic                clk,
  input logic                rst,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   sram_addr,
  input logic                sram_cs_n,
  input logic                sram_we_n,
  input logic                sram_oe_n,
  input logic [DATA_W/8-1:0] sram_lane_n,
  input logic [DATA_W-1:0]   sram_dq_out,
  input logic                sram_dq_oe
);
  localparam int CW = $clog2(WAIT_CYC + 2);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (since_q != CW'(WAIT_CYC)) since_q <= since_q + CW'(1);
  end

  p_ready_held_r1: assert property (@(posedge clk) disable iff (rst)
    (since_q != CW'(WAIT_CYC)) |-> !req_ready);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    sram_cs_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe && (&sram_lane_n)));

  p_we_after_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> $past(!sram_cs_n));

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n);

  p_lane_on_access_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_cs_n |-> !(&sram_lane_n));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_lane_n)));

  p_wdata_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));

  p_release_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WAIT_CYC (WAIT_CYC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .sram_addr   (sram_addr),
  .sram_cs_n   (sram_cs_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_lane_n (sram_lane_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  localparam int S   = 2;
  localparam int A   = 3;
  localparam int H   = 1;
  localparam int PWR = 125 * 150;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be    = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  rsp_be;
  logic [19:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_lane_n;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in;

  always #4 clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_be(rsp_be), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // behavioural memory on the pins (low 8 address bits select a word)
  logic [15:0] mem_arr [256];
  logic [15:0] shadow  [256];
  initial for (int i = 0; i < 256; i++) begin mem_arr[i] = '0; shadow[i] = '0; end

  always @(posedge sram_we_n) begin
    if (!rst && !sram_cs_n && sram_dq_oe) begin
      if (!sram_lane_n[0]) mem_arr[sram_addr[7:0]][7:0]  = sram_dq_out[7:0];
      if (!sram_lane_n[1]) mem_arr[sram_addr[7:0]][15:8] = sram_dq_out[15:8];
    end
  end

  always @* begin
    sram_dq_in[7:0]  = (!sram_cs_n && sram_we_n && !sram_oe_n && !sram_lane_n[0]) ?
                       mem_arr[sram_addr[7:0]][7:0]  : 8'hC3;
    sram_dq_in[15:8] = (!sram_cs_n && sram_we_n && !sram_oe_n && !sram_lane_n[1]) ?
                       mem_arr[sram_addr[7:0]][15:8] : 8'h3C;
  end

  // reference model
  int          edges = 0;
  int          pos   = 0;
  bit          busy  = 0;
  bit          m_wr  = 0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_wdata = '0;
  logic [1:0]  m_be = '0;
  bit          m_rsp_v = 0;
  logic [15:0] m_rsp_d = '0;
  logic [1:0]  m_rsp_be = '0;

  function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      edges = 0; busy = 0; pos = 0; m_rsp_v = 0;
    end else begin
      bit rdy;
      rdy = (edges >= PWR + 1) && !busy;
      m_rsp_v = 0;
      if (busy) begin
        pos++;
        if (pos > S + A + H) busy = 0;
        else if (!m_wr && pos == S + A + 1) begin
          m_rsp_v = 1; m_rsp_be = m_be;
          m_rsp_d = lane_mask(shadow[m_addr[7:0]], m_be);
        end
      end else if (rdy && req_valid) begin
        if (req_be != 2'b00) begin
          busy = 1; pos = 1; m_wr = req_write; m_addr = req_addr;
          m_wdata = req_wdata; m_be = req_be;
          if (req_write) begin
            if (req_be[0]) shadow[req_addr[7:0]][7:0]  = req_wdata[7:0];
            if (req_be[1]) shadow[req_addr[7:0]][15:8] = req_wdata[15:8];
          end
        end else if (!req_write) begin
          m_rsp_v = 1; m_rsp_d = '0; m_rsp_be = '0;
        end
      end
      if (edges < PWR + 10) edges++;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 40) $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      bit e_act, e_rdy;
      e_act = busy && pos > S && pos <= S + A;
      e_rdy = (edges >= PWR + 1) && !busy;
      chk(req_ready == e_rdy, "R1/R10 req_ready", 32'(req_ready), 32'(e_rdy));
      chk(sram_cs_n == !busy, "R2/R3 cs_n", 32'(sram_cs_n), 32'(!busy));
      chk(sram_we_n == !(e_act && m_wr), "R3 we_n", 32'(sram_we_n), 32'(!(e_act && m_wr)));
      chk(sram_oe_n == !(e_act && !m_wr), "R4/R6 oe_n", 32'(sram_oe_n), 32'(!(e_act && !m_wr)));
      chk(sram_lane_n == ~({2{busy}} & m_be), "R5 lane_n", 32'(sram_lane_n), 32'(~({2{busy}} & m_be)));
      chk(sram_dq_oe == (busy && m_wr), "R9 dq_oe", 32'(sram_dq_oe), 32'(busy && m_wr));
      if (busy) chk(sram_addr == m_addr, "R8 addr", 32'(sram_addr), 32'(m_addr));
      if (busy && m_wr) chk(sram_dq_out == m_wdata, "R8 wdata", 32'(sram_dq_out), 32'(m_wdata));
      chk(rsp_valid == m_rsp_v, "R6/R7 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
      if (m_rsp_v) begin
        chk(rsp_rdata == m_rsp_d, "R6/R7 rsp_rdata", 32'(rsp_rdata), 32'(m_rsp_d));
        chk(rsp_be == m_rsp_be, "R6/R7 rsp_be", 32'(rsp_be), 32'(m_rsp_be));
      end
    end
  end

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // scramble host inputs during the access (R8)
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_be = ~be; req_write = !wr;
    repeat (S + A + H + 1) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=%0d expected<60000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !req_ready,
        "R2 reset state", {27'd0, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 32'h1C);
    rst = 1'b0;
    // R1: request held pending through the whole power-up wait
    issue(1, 20'h00010, 16'hA5A5, 2'b11);
    issue(0, 20'h00010, 16'h0000, 2'b11);
    issue(1, 20'h00010, 16'h1234, 2'b01);   // R5 lower lane only
    issue(0, 20'h00010, 16'h0000, 2'b10);   // R6 expect A500
    issue(0, 20'h00010, 16'h0000, 2'b01);   // R6 expect 0034
    issue(1, 20'hFFFFF, 16'hBEEF, 2'b10);   // R5 upper lane only
    issue(0, 20'hFFFFF, 16'h0000, 2'b11);   // expect BE00
    issue(1, 20'h00010, 16'hFFFF, 2'b00);   // R7 empty write
    issue(0, 20'h00010, 16'h0000, 2'b11);   // R7 expect A534 unchanged
    issue(0, 20'h00020, 16'h0000, 2'b00);   // R7 empty read
    issue(1, 20'h00033, 16'h5AC3, 2'b11);
    issue(0, 20'h00033, 16'h0000, 2'b11);
    @(negedge clk);
    chk(mem_arr[8'h10] == 16'hA534, "R5 lane merge at 0x10", 32'(mem_arr[8'h10]), 32'hA534);
    chk(mem_arr[8'hFF] == 16'hBE00, "R5 upper write at 0xFFFFF", 32'(mem_arr[8'hFF]), 32'hBE00);
    chk(mem_arr[8'h20] == 16'h0000, "R7 empty read wrote nothing", 32'(mem_arr[8'h20]), 32'h0);
    chk(mem_arr[8'h33] == 16'h5AC3, "R3 full write at 0x33", 32'(mem_arr[8'h33]), 32'h5AC3);
    finish_run();
  end
endmodule